// File: doc/BRIEF.md
# Single-Wire Master Read-Bit Engine

This block is the master side of a bit-level read on a single open-drain data line held high by a pull-up. Each request produces one timed read frame. The engine pulls the line low for a short request interval and then lets go. It then decides the bit from the line level at a fixed sample point. A responder that wants to return a 0 keeps the line low past that point, and a responder returning a 1 never drives it. Acknowledge and not-acknowledge responses are read with the same frame: a low level is an acknowledge and a high level is a not-acknowledge.

The engine also measures the idle time since the last frame ended. When that gap is too long, the next request does not start its frame at once. The engine first waits until the line has been high for a required number of consecutive cycles, which forms a fresh start condition. All timing is given as parameters in system clock cycles. The line is seen through a drive-low enable output and a line input that passes through a two-flop synchronizer.

Top module: `swire_rdbit_master`

## Requirements
- R1: After reset, busy_o, done_o and drive_low_o are 0 and bit_o is 1. The first request after reset is treated as following a long idle gap (R7).
- R2: A request on req_i is taken at a rising clock edge only while busy_o is 0, and busy_o is 1 from the next cycle.
- R3: In every frame, drive_low_o is 1 for exactly REQ_CYC consecutive cycles, starting in the first cycle of the frame.
- R4: The decoded bit equals the line_i level during frame cycle SAMP_CYC-2, where frame cycle 0 is the first cycle with drive_low_o at 1. The offset of 2 comes from the synchronizer. Low decodes as 0 (data 0 or acknowledge) and high decodes as 1 (data 1 or not-acknowledge).
- R5: done_o is 1 for exactly one cycle, BIT_CYC cycles after frame cycle 0. busy_o falls in that same cycle. bit_o carries the decoded bit from then until the next done_o.
- R6: A request made while busy_o is 1 is dropped and never queued. Once the frame ends, no further frame and no further done_o follow unless a new request arrives.
- R7: Let n be the number of cycles from the done_o cycle to the accepting edge (n=1 for back-to-back). If n is greater than GAP_MAX, the frame starts only after HTSS_CYC consecutive synchronized high cycles. On an idle high line, done_o then comes HTSS_CYC+BIT_CYC cycles after acceptance. Otherwise done_o comes BIT_CYC cycles after acceptance.
- R8: A low level on line_i while the engine waits for the start condition restarts the high-time count. If line_i is low for L cycles starting in the first cycle after acceptance, done_o comes HTSS_CYC+BIT_CYC+L+2 cycles after acceptance.
- R9: drive_low_o is 1 only while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request to read one bit |
| line_i | input | 1 | Level of the shared line (asynchronous) |
| drive_low_o | output | 1 | Enable for the open-drain pull-down of the line |
| busy_o | output | 1 | Request taken and frame (or start wait) in progress |
| done_o | output | 1 | One-cycle pulse at frame completion |
| bit_o | output | 1 | Last decoded bit, 0 for low and 1 for high |

## Verification
The bound checker watches, on every cycle, the length of each drive-low pulse, the frame length from the first drive cycle to done_o, the single-cycle done_o pulse, and how busy_o relates to acceptance, drive and completion. The bench's scenarios are needed for what depends on the line and on the idle history. These are the decoded bit for each responder hold time, the exact point where an idle gap becomes long enough to force a start-condition wait, the restart of that wait when the line is low, and the silence after a request made while busy.

// File: rtl/swire_rdbit_pkg.sv
package swire_rdbit_pkg;

  // Engine phase: idle, waiting for a start-condition high time, or in a frame
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_GUARD = 2'd1,
    PH_FRAME = 2'd2
  } phase_e;

endpackage

// File: rtl/swire_line_sync.sv
module swire_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) stage_q[0] <= 1'b1;
          else       stage_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) stage_q[s] <= 1'b1;
          else       stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/swire_gap_tracker.sv
module swire_gap_tracker #(
  parameter int GAP_MAX = 25
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic frame_end_i,
  input  logic idle_i,
  output logic stale_o
);

  localparam int GW = $clog2(GAP_MAX + 2);
  localparam logic [GW-1:0] GAP_SAT = GW'(GAP_MAX + 1);
  localparam logic [GW-1:0] GAP_LIM = GW'(GAP_MAX);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                         gap_q <= GAP_SAT;
    else if (frame_end_i)              gap_q <= GW'(1);
    else if (idle_i && gap_q <= GAP_LIM) gap_q <= gap_q + GW'(1);
  end

  assign stale_o = (gap_q > GAP_LIM);

endmodule

// File: rtl/swire_frame_seq.sv
module swire_frame_seq
  import swire_rdbit_pkg::*;
#(
  parameter int BIT_CYC  = 20,
  parameter int REQ_CYC  = 3,
  parameter int SAMP_CYC = 8,
  parameter int HTSS_CYC = 10
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_i,
  input  logic line_s_i,
  input  logic stale_i,
  output logic frame_end_o,
  output logic idle_o,
  output logic drive_low_o,
  output logic busy_o,
  output logic done_o,
  output logic bit_o
);

  localparam int CW = $clog2(BIT_CYC);
  localparam int HW = $clog2(HTSS_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(BIT_CYC - 1);
  localparam logic [CW-1:0] CNT_SAMP = CW'(SAMP_CYC);
  localparam logic [CW-1:0] CNT_REQ  = CW'(REQ_CYC);
  localparam logic [HW-1:0] HT_LAST  = HW'(HTSS_CYC - 1);

  phase_e        ph_q, ph_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [HW-1:0] ht_q, ht_n;
  logic          samp_q, samp_n;
  logic          end_n;

  always_comb begin
    ph_n   = ph_q;
    cnt_n  = cnt_q;
    ht_n   = ht_q;
    samp_n = samp_q;
    end_n  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_i) begin
          cnt_n = '0;
          ht_n  = '0;
          ph_n  = stale_i ? PH_GUARD : PH_FRAME;
        end
      end
      PH_GUARD: begin
        if (line_s_i) begin
          if (ht_q == HT_LAST) begin
            ph_n  = PH_FRAME;
            cnt_n = '0;
          end else begin
            ht_n = ht_q + HW'(1);
          end
        end else begin
          ht_n = '0;
        end
      end
      PH_FRAME: begin
        if (cnt_q == CNT_SAMP) samp_n = line_s_i;
        if (cnt_q == CNT_LAST) begin
          ph_n  = PH_IDLE;
          end_n = 1'b1;
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ph_q        <= PH_IDLE;
      cnt_q       <= '0;
      ht_q        <= '0;
      samp_q      <= 1'b1;
      drive_low_o <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      bit_o       <= 1'b1;
    end else begin
      ph_q        <= ph_n;
      cnt_q       <= cnt_n;
      ht_q        <= ht_n;
      samp_q      <= samp_n;
      drive_low_o <= (ph_n == PH_FRAME) && (cnt_n < CNT_REQ);
      busy_o      <= (ph_n != PH_IDLE);
      done_o      <= end_n;
      if (end_n) bit_o <= samp_n;
    end
  end

  assign frame_end_o = end_n;
  assign idle_o      = (ph_q == PH_IDLE);

endmodule

// File: rtl/swire_rdbit_master.sv
module swire_rdbit_master #(
  parameter int BIT_CYC    = 20,
  parameter int REQ_CYC    = 3,
  parameter int SAMP_CYC   = 8,
  parameter int GAP_MAX    = 25,
  parameter int HTSS_CYC   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_i,
  input  logic line_i,
  output logic drive_low_o,
  output logic busy_o,
  output logic done_o,
  output logic bit_o
);

  logic line_s;
  logic stale;
  logic frame_end;
  logic idle;

  swire_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .async_i (line_i),
    .sync_o  (line_s)
  );

  swire_gap_tracker #(.GAP_MAX(GAP_MAX)) gap_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .frame_end_i (frame_end),
    .idle_i      (idle),
    .stale_o     (stale)
  );

  swire_frame_seq #(
    .BIT_CYC  (BIT_CYC),
    .REQ_CYC  (REQ_CYC),
    .SAMP_CYC (SAMP_CYC),
    .HTSS_CYC (HTSS_CYC)
  ) seq_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .req_i       (req_i),
    .line_s_i    (line_s),
    .stale_i     (stale),
    .frame_end_o (frame_end),
    .idle_o      (idle),
    .drive_low_o (drive_low_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .bit_o       (bit_o)
  );

endmodule

// File: rtl/swire_rdbit_chk.sv
module swire_rdbit_chk #(
  parameter int BIT_CYC = 20,
  parameter int REQ_CYC = 3
) (
  input logic clk_i,
  input logic rst_i,
  input logic req_i,
  input logic drive_low_o,
  input logic busy_o,
  input logic done_o
);

  localparam int FW = $clog2(BIT_CYC + 2);
  localparam logic [FW-1:0] F_SAT = FW'(BIT_CYC + 1);

  logic [FW-1:0] drv_run_q;
  logic [FW-1:0] frm_q;
  logic          drv_prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      drv_run_q  <= '0;
      frm_q      <= F_SAT;
      drv_prev_q <= 1'b0;
    end else begin
      drv_prev_q <= drive_low_o;
      drv_run_q  <= drive_low_o ? drv_run_q + FW'(1) : '0;
      if (drive_low_o && !drv_prev_q) frm_q <= FW'(1);
      else if (frm_q < F_SAT)         frm_q <= frm_q + FW'(1);
    end
  end

  assert_drive_short_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    drive_low_o |-> (drv_run_q < FW'(REQ_CYC)));

  assert_drive_full_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(drive_low_o) |-> (drv_run_q == FW'(REQ_CYC)));

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  assert_frame_len_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> (frm_q == FW'(BIT_CYC)));

  assert_busy_end_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(busy_o) |-> done_o);

  assert_done_idle_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> !busy_o);

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i && !busy_o) |=> busy_o);

  assert_drive_busy_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    drive_low_o |-> busy_o);

endmodule

bind swire_rdbit_master swire_rdbit_chk #(
  .BIT_CYC (BIT_CYC),
  .REQ_CYC (REQ_CYC)
) chk_i (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .req_i       (req_i),
  .drive_low_o (drive_low_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/swire_rdbit_master_tb_top.sv
module swire_rdbit_master_tb_top;

  localparam int BIT_CYC  = 20;
  localparam int REQ_CYC  = 3;
  localparam int SAMP_CYC = 8;
  localparam int GAP_MAX  = 25;
  localparam int HTSS_CYC = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic ext_low = 1'b0;
  logic drive_low, busy, done_p, bit_v;
  logic line;
  logic slave_low;
  logic dprev = 1'b0;
  int   fc = 1000;
  int   hold = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  // Responder model: pulls the line low for 'hold' cycles from frame cycle 0
  always @(posedge clk) begin
    dprev <= drive_low;
    if (drive_low && !dprev) fc <= 1;
    else if (fc < 1000)      fc <= fc + 1;
  end
  assign slave_low = (drive_low && !dprev) ? (hold > 0) : (fc < hold);
  assign line = !(drive_low || slave_low || ext_low);

  swire_rdbit_master #(
    .BIT_CYC (BIT_CYC), .REQ_CYC (REQ_CYC), .SAMP_CYC (SAMP_CYC),
    .GAP_MAX (GAP_MAX), .HTSS_CYC (HTSS_CYC), .SYNC_STAGES (2)
  ) dut_i (
    .clk_i (clk), .rst_i (rst), .req_i (req), .line_i (line),
    .drive_low_o (drive_low), .busy_o (busy), .done_o (done_p), .bit_o (bit_v)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Issue a request at the current negedge and measure the frame.
  // low_len > 0 pulls the line low for that many cycles after acceptance.
  task automatic run_bit(input int h, input int exp_lat, input int low_len, input string tag);
    int lat;
    int drv;
    int exp_bit;
    hold = h;
    req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    if (low_len > 0) ext_low = 1'b1;
    check(busy === 1'b1, {tag, " R2 busy after accept"}, busy, 1);
    lat = 0;
    drv = 0;
    while (!done_p && lat < 300) begin
      if (drive_low) drv++;
      @(negedge clk);
      lat++;
      if (lat == low_len) ext_low = 1'b0;
    end
    exp_bit = ((SAMP_CYC - 2) < h || (SAMP_CYC - 2) < REQ_CYC) ? 0 : 1;
    check(lat == exp_lat, {tag, " R5/R7 done latency"}, lat, exp_lat);
    check(drv == REQ_CYC, {tag, " R3 drive length"}, drv, REQ_CYC);
    check(bit_v == exp_bit[0], {tag, " R4 decoded bit"}, bit_v, exp_bit);
    check(busy === 1'b0, {tag, " R5 busy falls with done"}, busy, 0);
    hold = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(busy === 1'b0 && done_p === 1'b0 && drive_low === 1'b0, "R1 outputs idle", busy, 0);
    check(bit_v === 1'b1, "R1 bit_o reset", bit_v, 1);
    // R1: first request after reset waits for the start condition
    run_bit(0, HTSS_CYC + BIT_CYC, 0, "R1 first frame");

    // R4: sweep responder hold time, back-to-back frames (R7 short gap)
    for (int h = 0; h <= BIT_CYC - 2; h++) run_bit(h, BIT_CYC, 0, "R4 hold sweep");

    // R7: sweep idle gap around GAP_MAX
    for (int w = GAP_MAX - 3; w <= GAP_MAX + 2; w++) begin
      repeat (w) @(negedge clk);
      run_bit((w % 2 == 0) ? BIT_CYC - 3 : 0,
              (w + 1 > GAP_MAX) ? HTSS_CYC + BIT_CYC : BIT_CYC, 0, "R7 gap sweep");
    end

    // R8: low line during start wait restarts the count
    for (int l = 1; l <= 4; l++) begin
      repeat (GAP_MAX + 1) @(negedge clk);
      run_bit(0, HTSS_CYC + BIT_CYC + l + 2, l, "R8 guard restart");
    end

    // R6: request while busy is dropped
    begin
      int extra_drv;
      int extra_done;
      int h6;
      h6 = BIT_CYC - 2;
      hold = h6;
      req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0;
      repeat (3) @(negedge clk);
      hold = h6;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      while (!done_p) @(negedge clk);
      check(bit_v == 1'b0, "R6 first frame bit", bit_v, 0);
      hold = 0;
      extra_drv = 0;
      extra_done = 0;
      repeat (BIT_CYC + HTSS_CYC + 8) begin
        @(negedge clk);
        if (drive_low) extra_drv++;
        if (done_p) extra_done++;
      end
      check(extra_drv == 0, "R6 no queued frame drive", extra_drv, 0);
      check(extra_done == 0, "R6 no queued done", extra_done, 0);
      check(bit_v == 1'b0 && busy == 1'b0, "R6 bit_o held, R9 idle", bit_v, 0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R5 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule